// File: doc/BRIEF.md
# Double-Buffered DAC Input Front End

This block sits between a processor bus and a 10-bit digital-to-analog converter. Incoming bus data goes first into a 10-bit input latch. A second 10-bit DAC register holds the code that is driven to the converter. Because of the two levels, the converter never sees a half-assembled word. A word can arrive in one write from a 16-bit bus, or in two writes from an 8-bit bus. A static input selects left-justified (fractional, MSB weighs one half of full scale) or right-justified (positional, LSB weighs 1/1024 of full scale) placement.

The first write of a word always loads all ten latch bits. An optional second write in byte mode patches only the two bits that the first byte could not reach. The latch is copied into the DAC register in one of three ways:
- automatically, when the word becomes complete;
- on a shared processor transfer command, so that many converters change at once;
- on an external strobe.

All strobes are synchronized to one clock and acted on at one edge. A status flag shows that the latch holds data that has not been transferred yet.

Top module: `dac_dbuf_front`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the DAC register, the input latch, the pending flag and the byte pointer. One clock edge after `rst` is sampled high, `dac_code` is 0 and `pending` is 0. A later transfer with no new write delivers 0.
- R2: A write happens only while `cs_n` and `wr_n` are both low. The write is committed at the end of the write cycle, when either strobe returns high. Both strobes pass through a two-stage synchronizer, so the commit takes effect on the third rising clock edge after the release. A low `wr_n` with `cs_n` high has no effect.
- R3: With `bus_wide`=1, one write loads the whole code. Left-justified takes `din[15:6]`. Right-justified takes `din[9:0]`.
- R4: Left-justified byte mode works as follows. The first write loads `din[7:0]` into latch bits [9:2] and clears latch bits [1:0]. The second write places `din[7:6]` into latch bits [1:0] and leaves bits [9:2] as they are.
- R5: Right-justified byte mode works as follows. The first write loads `din[7:0]` into latch bits [7:0] and clears latch bits [9:8]. The second write places `din[1:0]` into latch bits [9:8] and leaves bits [7:0] as they are.
- R6: A byte pointer picks first or second write in byte mode. It toggles on every committed write with `bus_wide`=0. A write with `bus_wide`=1 leaves it unchanged. It returns to "first" after an automatic transfer and after reset.
- R7: `xfer_mode`=2'b00 (automatic) copies the latch into the DAC register at the same edge that commits a second byte write, or any write with `bus_wide`=1.
- R8: `xfer_mode`=2'b01 (command) copies the latch when `xfer_n` returns high after a low pulse. This takes effect on the third rising edge after the release. Writes and `ext_stb` alone do not change `dac_code`.
- R9: `xfer_mode`=2'b10 (external strobe) copies the latch on a rising edge of `ext_stb`, taking effect on the third rising clock edge after the rise. Writes and `xfer_n` alone do not change `dac_code`.
- R10: `xfer_mode`=2'b11 (hold) performs no transfer. `dac_code` keeps its value, while writes still load the latch.
- R11: `pending` is set by a committed write that is not transferred at the same edge. It is cleared by any transfer.
- R12: `dac_code` changes only at a transfer. A first byte write never appears on it, even in automatic mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all storage |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| xfer_n | input | 1 | Processor transfer command, active low, commits on release |
| ext_stb | input | 1 | External transfer strobe, rising edge |
| bus_wide | input | 1 | 1: 16-bit single write, 0: two byte writes |
| left_just | input | 1 | 1: left-justified, 0: right-justified |
| xfer_mode | input | 2 | 00 auto, 01 command, 10 external strobe, 11 hold |
| din | input | 16 | Bus data |
| dac_code | output | 10 | Code driven to the converter |
| pending | output | 1 | Latch holds data not yet transferred |

## Verification
Wide writes are tried in both justifications, with bit patterns whose halves differ. A wrong slice of the bus then gives a different code. Byte pairs are run in both justifications, with second bytes whose significant two bits differ from their other bits. This separates a correct two-bit patch from a whole-byte overwrite, and shows whether the first byte cleared the bits it does not own. Each transfer mode is paired with pulses on the strobes that it must ignore. A wide write is placed between two byte writes, and a reset is placed after a lone first byte. Together these show whether the pointer ignores wide writes and returns to "first".

// File: rtl/dacfe_pkg.sv
`timescale 1ns/1ps
package dacfe_pkg;
  localparam int CODE_W = 10;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;
  localparam int LOW_W  = CODE_W - BYTE_W;

  typedef enum logic [1:0] {
    XF_AUTO = 2'b00,
    XF_CMD  = 2'b01,
    XF_EXT  = 2'b10,
    XF_HOLD = 2'b11
  } xfer_mode_e;

  // whole code from one wide write
  function automatic logic [CODE_W-1:0] load_full(input logic [BUS_W-1:0] d, input logic left);
    return left ? d[BUS_W-1 -: CODE_W] : d[CODE_W-1:0];
  endfunction

  // first byte: fills all latch bits, the part it cannot reach is cleared
  function automatic logic [CODE_W-1:0] load_first(input logic [BUS_W-1:0] d, input logic left);
    return left ? {d[BYTE_W-1:0], {LOW_W{1'b0}}} : {{LOW_W{1'b0}}, d[BYTE_W-1:0]};
  endfunction

  // second byte: patches only the LOW_W bits the first one missed
  function automatic logic [CODE_W-1:0] patch_second(input logic [CODE_W-1:0] cur,
                                                    input logic [BUS_W-1:0] d,
                                                    input logic left);
    logic [CODE_W-1:0] r;
    r = cur;
    if (left) r[LOW_W-1:0] = d[BYTE_W-1 -: LOW_W];
    else      r[CODE_W-1 -: LOW_W] = d[LOW_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/dacfe_edge_sync.sv
`timescale 1ns/1ps
module dacfe_edge_sync #(
  parameter int STAGES = 2,
  parameter bit RISE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic evt
);
  logic [STAGES-1:0] sh;
  logic              prev;
  logic              synced;

  assign synced = sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], lvl};
      prev <= synced;
    end
  end

  generate
    if (RISE) begin : g_rise
      assign evt = synced & ~prev;
    end else begin : g_fall
      assign evt = ~synced & prev;
    end
  endgenerate

  // R2: an edge event lasts exactly one cycle
  a_r2_evt_single: assert property (@(posedge clk) disable iff (rst) evt |=> !evt);
endmodule

// File: rtl/dacfe_input_latch.sv
`timescale 1ns/1ps
module dacfe_input_latch
  import dacfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic              wide,
  input  logic              left,
  input  logic              ptr_clr,
  input  logic [BUS_W-1:0]  din,
  output logic [CODE_W-1:0] latch_q,
  output logic [CODE_W-1:0] latch_nx,
  output logic              second_wr
);
  logic ptr_second;

  always_comb begin
    latch_nx = latch_q;
    if (wr_evt) begin
      if (wide)             latch_nx = load_full(din, left);
      else if (!ptr_second) latch_nx = load_first(din, left);
      else                  latch_nx = patch_second(latch_q, din, left);
    end
  end

  assign second_wr = wr_evt & ~wide & ptr_second;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q    <= '0;
      ptr_second <= 1'b0;
    end else begin
      latch_q <= latch_nx;
      if (ptr_clr)               ptr_second <= 1'b0;
      else if (wr_evt && !wide)  ptr_second <= ~ptr_second;
    end
  end

  // R4: left-justified first byte clears the two low bits
  a_r4_first_clears_low: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !wide && !ptr_second && left) |=> (latch_q[LOW_W-1:0] == '0));
  // R5: right-justified first byte clears the two high bits
  a_r5_first_clears_high: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !wide && !ptr_second && !left) |=> (latch_q[CODE_W-1 -: LOW_W] == '0));
  // R6: wide writes leave the byte pointer alone
  a_r6_ptr_wide_stable: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && wide && !ptr_clr) |=> $stable(ptr_second));
  // R6: pointer is back to first after a clear
  a_r6_ptr_cleared: assert property (@(posedge clk) disable iff (rst)
    ptr_clr |=> !ptr_second);
endmodule

// File: rtl/dac_dbuf_front.sv
`timescale 1ns/1ps
module dac_dbuf_front
  import dacfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              xfer_n,
  input  logic              ext_stb,
  input  logic              bus_wide,
  input  logic              left_just,
  input  logic [1:0]        xfer_mode,
  input  logic [BUS_W-1:0]  din,
  output logic [CODE_W-1:0] dac_code,
  output logic              pending
);
  logic              wr_evt;
  logic              cmd_evt;
  logic              ext_evt;
  logic              xfer_fire;
  logic              auto_fire;
  logic              second_wr;
  logic [CODE_W-1:0] latch_q;
  logic [CODE_W-1:0] latch_nx;
  xfer_mode_e        mode;

  assign mode = xfer_mode_e'(xfer_mode);

  // write commits when the combined active strobe ends
  dacfe_edge_sync #(.STAGES(SYNC_STAGES), .RISE(1'b0)) u_wr_sync (
    .clk(clk), .rst(rst), .lvl(~cs_n & ~wr_n), .evt(wr_evt));
  // command transfer commits on release of xfer_n
  dacfe_edge_sync #(.STAGES(SYNC_STAGES), .RISE(1'b0)) u_cmd_sync (
    .clk(clk), .rst(rst), .lvl(~xfer_n), .evt(cmd_evt));
  // external strobe acts on its rising edge
  dacfe_edge_sync #(.STAGES(SYNC_STAGES), .RISE(1'b1)) u_ext_sync (
    .clk(clk), .rst(rst), .lvl(ext_stb), .evt(ext_evt));

  dacfe_input_latch u_latch (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .wide(bus_wide), .left(left_just),
    .ptr_clr(auto_fire), .din(din), .latch_q(latch_q), .latch_nx(latch_nx),
    .second_wr(second_wr));

  assign auto_fire = (mode == XF_AUTO) & wr_evt & (bus_wide | second_wr);

  always_comb begin
    unique case (mode)
      XF_AUTO: xfer_fire = auto_fire;
      XF_CMD:  xfer_fire = cmd_evt;
      XF_EXT:  xfer_fire = ext_evt;
      default: xfer_fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code <= '0;
      pending  <= 1'b0;
    end else begin
      if (xfer_fire) begin
        dac_code <= latch_nx;
        pending  <= 1'b0;
      end else if (wr_evt) begin
        pending  <= 1'b1;
      end
    end
  end

  // R1: reset empties the outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && !pending));
  // R12: no transfer, no change on the converter code
  a_r12_no_partial: assert property (@(posedge clk) disable iff (rst)
    !xfer_fire |=> $stable(dac_code));
  // R10: hold mode freezes the code
  a_r10_hold_mode: assert property (@(posedge clk) disable iff (rst)
    (mode == XF_HOLD && !wr_evt) |=> $stable(dac_code));
  // R7: a completing write in auto mode leaves both levels equal
  a_r7_auto_match: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && mode == XF_AUTO && (bus_wide || second_wr)) |=> (dac_code == latch_q));
  // R11: untransferred write raises pending
  a_r11_pend_set: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !xfer_fire) |=> pending);
  // R11: a transfer clears pending
  a_r11_pend_clr: assert property (@(posedge clk) disable iff (rst)
    xfer_fire |=> !pending);
endmodule

// File: tb/dac_dbuf_front_test.sv
`timescale 1ns/1ps
module dac_dbuf_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        xfer_n = 1'b1;
  logic        ext_stb = 1'b0;
  logic        bus_wide = 1'b1;
  logic        left_just = 1'b1;
  logic [1:0]  xfer_mode = 2'b00;
  logic [15:0] din = '0;
  logic [9:0]  dac_code;
  logic        pending;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbuf_front uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .xfer_n(xfer_n),
    .ext_stb(ext_stb), .bus_wide(bus_wide), .left_just(left_just),
    .xfer_mode(xfer_mode), .din(din), .dac_code(dac_code), .pending(pending));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // strobe histories: index 0 = newest sample seen by the design
  int wh[3], ch[3], eh[3];
  int m_latch = 0, m_dac = 0, m_pend = 0, m_second = 0;
  bit m_valid = 0;

  always @(negedge clk) begin
    int wf, cf, ef, fire, nl, is2;
    if (m_valid && !done) begin
      chk("R12 model dac_code", int'(dac_code), m_dac);
      chk("R11 model pending", int'(pending), m_pend);
    end
    if (rst) begin
      m_latch = 0; m_dac = 0; m_pend = 0; m_second = 0;
      for (int i = 0; i < 3; i++) begin wh[i] = 0; ch[i] = 0; eh[i] = 0; end
    end else begin
      wf = (wh[2] == 1 && wh[1] == 0) ? 1 : 0;
      cf = (ch[2] == 1 && ch[1] == 0) ? 1 : 0;
      ef = (eh[2] == 0 && eh[1] == 1) ? 1 : 0;
      nl = m_latch; is2 = 0;
      if (wf == 1) begin
        if (bus_wide)
          nl = left_just ? (int'(din) >> 6) : (int'(din) % 1024);
        else if (m_second == 0)
          nl = left_just ? ((int'(din) % 256) * 4) : (int'(din) % 256);
        else begin
          is2 = 1;
          nl = left_just ? ((m_latch / 4) * 4 + (int'(din) / 64) % 4)
                         : ((m_latch % 256) + (int'(din) % 4) * 256);
        end
      end
      fire = 0;
      if (xfer_mode == 2'b00 && wf == 1 && (bus_wide || is2 == 1)) fire = 1;
      if (xfer_mode == 2'b01 && cf == 1) fire = 1;
      if (xfer_mode == 2'b10 && ef == 1) fire = 1;
      if (wf == 1 && !bus_wide) m_second = 1 - m_second;
      if (xfer_mode == 2'b00 && fire == 1) m_second = 0;
      if (fire == 1) begin m_dac = nl; m_pend = 0; end
      else if (wf == 1) m_pend = 1;
      m_latch = nl;
      for (int i = 2; i > 0; i--) begin wh[i] = wh[i-1]; ch[i] = ch[i-1]; eh[i] = eh[i-1]; end
      wh[0] = (!cs_n && !wr_n) ? 1 : 0;
      ch[0] = (!xfer_n) ? 1 : 0;
      eh[0] = ext_stb ? 1 : 0;
    end
    m_valid = 1;
  end

  // ---------------- stimulus helpers ----------------
  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] m, input logic w, input logic l);
    @(posedge clk); #1;
    xfer_mode = m; bus_wide = w; left_just = l;
  endtask

  task automatic bus_write(input logic [15:0] d);
    @(posedge clk); #1;
    din = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    wr_n = 1'b1; cs_n = 1'b1;
    settle();
  endtask

  task automatic cmd_pulse();
    @(posedge clk); #1; xfer_n = 1'b0;
    repeat (2) @(posedge clk); #1; xfer_n = 1'b1;
    settle();
  endtask

  task automatic ext_pulse();
    @(posedge clk); #1; ext_stb = 1'b1;
    repeat (2) @(posedge clk); #1; ext_stb = 1'b0;
    settle();
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst = 1'b1;
    repeat (3) @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      summary();
    end
  end

  initial begin
    repeat (4) @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk("R1 reset dac_code", int'(dac_code), 0);
    chk("R1 reset pending", int'(pending), 0);

    // R3/R7 wide writes, auto mode
    bus_write(16'hABC0);
    chk("R3 wide left", int'(dac_code), 'h2AF);
    chk("R7 auto clears pending", int'(pending), 0);
    cfg(2'b00, 1'b1, 1'b0);
    bus_write(16'hFD5A);
    chk("R3 wide right", int'(dac_code), 'h15A);

    // R4 left byte pair, R12 first byte hidden
    cfg(2'b00, 1'b0, 1'b1);
    bus_write(16'h00C3);
    chk("R12 first byte not shown", int'(dac_code), 'h15A);
    chk("R11 pending after first byte", int'(pending), 1);
    bus_write(16'h0080);
    chk("R4 left byte pair", int'(dac_code), 'h30E);

    // R5 right byte pair (pointer back to first after auto transfer)
    cfg(2'b00, 1'b0, 1'b0);
    bus_write(16'h005A);
    chk("R12 right first byte hidden", int'(dac_code), 'h30E);
    bus_write(16'h0003);
    chk("R5 right byte pair", int'(dac_code), 'h35A);

    // R2 unqualified strobes
    @(posedge clk); #1; wr_n = 1'b0;
    repeat (2) @(posedge clk); #1; wr_n = 1'b1;
    settle();
    @(posedge clk); #1; cs_n = 1'b0;
    repeat (2) @(posedge clk); #1; cs_n = 1'b1;
    settle();
    chk("R2 no write without both strobes", int'(pending), 0);
    chk("R2 code unchanged", int'(dac_code), 'h35A);

    // R8 command mode
    cfg(2'b01, 1'b1, 1'b0);
    bus_write(16'h0123);
    chk("R8 write alone holds code", int'(dac_code), 'h35A);
    chk("R11 pending in command mode", int'(pending), 1);
    ext_pulse();
    chk("R8 ext strobe ignored", int'(dac_code), 'h35A);
    cmd_pulse();
    chk("R8 command transfer", int'(dac_code), 'h123);
    chk("R11 pending cleared", int'(pending), 0);

    // R9 external strobe mode
    cfg(2'b10, 1'b1, 1'b0);
    bus_write(16'h02AA);
    cmd_pulse();
    chk("R9 command ignored", int'(dac_code), 'h123);
    ext_pulse();
    chk("R9 ext transfer", int'(dac_code), 'h2AA);

    // R10 hold mode
    cfg(2'b11, 1'b1, 1'b0);
    bus_write(16'h0055);
    cmd_pulse();
    ext_pulse();
    chk("R10 hold keeps code", int'(dac_code), 'h2AA);
    chk("R10 latch still loaded", int'(pending), 1);
    cfg(2'b01, 1'b1, 1'b0);
    cmd_pulse();
    chk("R10 latch value kept", int'(dac_code), 'h055);

    // R6 wide write between bytes leaves pointer on second
    cfg(2'b01, 1'b0, 1'b1);
    bus_write(16'h0011);
    cfg(2'b01, 1'b1, 1'b1);
    bus_write(16'h8000);
    cfg(2'b01, 1'b0, 1'b1);
    bus_write(16'h00C0);
    cmd_pulse();
    chk("R6 pointer ignores wide write", int'(dac_code), 'h203);

    // R1/R6 reset clears latch and pointer
    bus_write(16'h0077);
    do_reset();
    chk("R1 reset clears code", int'(dac_code), 0);
    cmd_pulse();
    chk("R1 reset clears latch", int'(dac_code), 0);
    cfg(2'b00, 1'b0, 1'b1);
    bus_write(16'h00E2);
    chk("R6 pointer first after reset", int'(dac_code), 0);
    bus_write(16'h0040);
    chk("R7 auto on second byte", int'(dac_code), 'h389);

    summary();
  end
endmodule